// File: doc/BRIEF.md
# Power-Up Reset Time-Out Sequencer

This block keeps the internal chip reset active after the supply comes up and after other reset and wake events, until the delays the clock source needs have run out. It has three delays in a chain. The first is a power-up delay counted in edges of a slow, free-running RC tick. The second is an oscillator start-up delay counted in cycles of the oscillator clock, used only with crystal sources. The third is a PLL lock delay, used only when the PLL is selected. Which delays run depends on the event that started the sequence, on the oscillator mode code, and on two enable bits.

A brown-out reset is taken only after the supply-low flag has stayed high for a minimum number of RC ticks. While the supply stays low the chip is held in reset. When the supply recovers, the power-up delay runs again from zero. The external reset pin and the power-on pulse set the reset output at once, without waiting for a clock edge. Reset is released only on an oscillator clock edge, through a synchronizer. When the external pin is released after every delay has already finished, the reset is released within a few cycles. All delay lengths are parameters, so the block can be scaled down for simulation.

Top module: `rst_timeout_seq`

## Requirements
- R1: `chip_rst` goes high with no clock edge needed while `por_pulse` is high or `ext_rst_n` is low.
- R2: After `por_pulse` falls with `pwrt_en` = 1, reset stays high for PWRT_TICKS rising edges of `rc_tick` before any later delay starts.
- R3: With `pwrt_en` = 0, the power-up delay is skipped and the sequence goes straight to the next stage.
- R4: In the crystal modes (`osc_mode` 0, 1, 2 and 6), a start-up delay of OST_CYCLES clock cycles runs after the power-up stage. This happens after a power-on pulse or a wake event only.
- R5: In mode 6 (PLL), a lock delay of PLL_CYCLES clock cycles runs after the start-up delay.
- R6: In the non-crystal modes (`osc_mode` 3, 4, 5 and 7) with `pwrt_en` = 0, reset is released within 4 cycles after `por_pulse` falls.
- R7: With `bor_en` = 1, a `vdd_low` level that lasts at least BOR_MIN_TICKS tick edges asserts reset. A shorter dip leaves `chip_rst` low.
- R8: After a brown-out, reset stays high while `vdd_low` is high. After recovery only the power-up delay runs, with no start-up delay even in crystal modes.
- R9: A brown-out that qualifies while the power-up delay is running restarts that delay from zero after recovery.
- R10: With `bor_en` = 0, `vdd_low` has no effect on `chip_rst`.
- R11: An external reset starts no delay. If all delays have finished, `chip_rst` falls within 3 clock cycles after `ext_rst_n` rises.
- R12: A one-cycle `wake` in a running crystal mode asserts reset and runs the start-up delay, plus the lock delay in mode 6. In non-crystal modes, `wake` is ignored.
- R13: `chip_rst` falls only on a clock edge, and only after the sequencer has reached its run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; drives the start-up and lock counters |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| rc_tick | input | 1 | Slow free-running RC square wave, asynchronous to `clk` |
| vdd_low | input | 1 | Brown-out comparator flag, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wake | input | 1 | Wake-from-sleep event, one cycle wide, synchronous |
| osc_mode | input | 3 | Oscillator mode code: 0, 1, 2 crystal; 6 crystal with PLL; 3, 4, 5, 7 RC or external clock |
| pwrt_en | input | 1 | Enables the power-up delay |
| bor_en | input | 1 | Enables brown-out detection |
| chip_rst | output | 1 | Internal chip reset, active high |

## Verification
Power-on is tried in four combinations: a plain crystal mode, the PLL mode, a crystal mode with the power-up delay turned off, and an external-clock mode with and without that delay. Comparing the release times shows which delay stages took part. Brown-out is driven four ways: as a dip shorter than the filter, as a long dip, as a second dip in the middle of the power-up delay, and with detection turned off. These separate the filter, the hold-while-low behaviour, the restart of the delay, and the enable. Wake events in a crystal mode, the PLL mode and an external-clock mode show that the start-up chain follows the mode. The external pin is pulsed both during normal running and across a full power-up to show that it never adds a delay.

// File: rtl/rts_pkg.sv
package rts_pkg;

   typedef enum logic [2:0] {
      ST_PWR = 3'd0,
      ST_OST = 3'd1,
      ST_PLL = 3'd2,
      ST_RUN = 3'd3,
      ST_LOW = 3'd4
   } seq_state_e;

   localparam logic [2:0] MODE_HSPLL = 3'd6;

   // crystal sources need the start-up count
   function automatic logic is_xtal(input logic [2:0] m);
      return (m == 3'd0) || (m == 3'd1) || (m == 3'd2) || (m == MODE_HSPLL);
   endfunction

   function automatic logic is_pll(input logic [2:0] m);
      return m == MODE_HSPLL;
   endfunction

endpackage

// File: rtl/rts_sync.sv
module rts_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rts_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or posedge arst) begin
      if (arst) pipe_q <= {STAGES{RST_VAL}};
      else      pipe_q <= {pipe_q[STAGES-2:0], d};
   end

   assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/rts_delay.sv
module rts_delay #(
   parameter int LEN = 16
) (
   input  logic clk,
   input  logic arst,
   input  logic run,
   input  logic step,
   output logic done
);
   localparam int         W    = $clog2(LEN + 1);
   localparam logic [W-1:0] LAST = W'(LEN);

   logic [W-1:0] cnt_q;

   generate
      if (LEN < 1) begin : g_bad_len
         $error("rts_delay: LEN must be at least 1");
      end
   endgenerate

   // clears whenever the owning stage is not active, saturates at LEN
   always_ff @(posedge clk or posedge arst) begin
      if (arst)                        cnt_q <= '0;
      else if (!run)                   cnt_q <= '0;
      else if (step && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
   end

   assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/rts_brownout.sv
module rts_brownout #(
   parameter int SYNC_STAGES   = 2,
   parameter int BOR_MIN_TICKS = 4
) (
   input  logic clk,
   input  logic arst,
   input  logic vdd_low,
   input  logic bor_en,
   input  logic tick,
   output logic low_s,
   output logic trip
);
   logic qual_run;

   rts_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_low_sync (
      .clk (clk),
      .arst(arst),
      .d   (vdd_low),
      .q   (low_s)
   );

   assign qual_run = low_s && bor_en;

   // a dip must last BOR_MIN_TICKS tick edges to trip
   rts_delay #(.LEN(BOR_MIN_TICKS)) i_filter (
      .clk (clk),
      .arst(arst),
      .run (qual_run),
      .step(tick),
      .done(trip)
   );
endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq
   import rts_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int PWRT_TICKS    = 2304,
   parameter int OST_CYCLES    = 1024,
   parameter int PLL_CYCLES    = 20000,
   parameter int BOR_MIN_TICKS = 4
) (
   input  logic       clk,
   input  logic       por_pulse,
   input  logic       rc_tick,
   input  logic       vdd_low,
   input  logic       ext_rst_n,
   input  logic       wake,
   input  logic [2:0] osc_mode,
   input  logic       pwrt_en,
   input  logic       bor_en,
   output logic       chip_rst
);
   seq_state_e state_q, state_d;
   logic       need_ost_q, need_ost_d;
   logic       rc_s, rc_d_q, tick;
   logic       low_s, bor_trip;
   logic       arst_ext, ext_ok;
   logic       pwr_done, ost_done, pll_done;
   logic       chip_rst_q;

   generate
      if (PWRT_TICKS < 1 || OST_CYCLES < 1 || BOR_MIN_TICKS < 1) begin : g_bad_len
         $error("rst_timeout_seq: delay lengths must be positive");
      end
   endgenerate

   // slow RC tick brought into the oscillator domain as a one-cycle enable
   rts_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_tick_sync (
      .clk (clk),
      .arst(por_pulse),
      .d   (rc_tick),
      .q   (rc_s)
   );

   always_ff @(posedge clk or posedge por_pulse) begin
      if (por_pulse) rc_d_q <= 1'b0;
      else           rc_d_q <= rc_s;
   end

   assign tick = rc_s && !rc_d_q;

   rts_brownout #(.SYNC_STAGES(SYNC_STAGES), .BOR_MIN_TICKS(BOR_MIN_TICKS)) i_bor (
      .clk    (clk),
      .arst   (por_pulse),
      .vdd_low(vdd_low),
      .bor_en (bor_en),
      .tick   (tick),
      .low_s  (low_s),
      .trip   (bor_trip)
   );

   // external pin and power-on: asynchronous assert, synchronous release
   assign arst_ext = por_pulse || !ext_rst_n;

   rts_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_ext_sync (
      .clk (clk),
      .arst(arst_ext),
      .d   (1'b1),
      .q   (ext_ok)
   );

   rts_delay #(.LEN(PWRT_TICKS)) i_pwr_cnt (
      .clk (clk),
      .arst(por_pulse),
      .run (state_q == ST_PWR),
      .step(tick),
      .done(pwr_done)
   );

   rts_delay #(.LEN(OST_CYCLES)) i_ost_cnt (
      .clk (clk),
      .arst(por_pulse),
      .run (state_q == ST_OST),
      .step(1'b1),
      .done(ost_done)
   );

   generate
      if (PLL_CYCLES > 0) begin : g_pll_cnt
         rts_delay #(.LEN(PLL_CYCLES)) i_pll_cnt (
            .clk (clk),
            .arst(por_pulse),
            .run (state_q == ST_PLL),
            .step(1'b1),
            .done(pll_done)
         );
      end else begin : g_no_pll_cnt
         assign pll_done = 1'b1;
      end
   endgenerate

   always_comb begin
      state_d    = state_q;
      need_ost_d = need_ost_q;
      if (bor_trip && state_q != ST_LOW) begin
         state_d    = ST_LOW;
         need_ost_d = 1'b0;
      end else begin
         unique case (state_q)
            ST_LOW: if (!(low_s && bor_en)) state_d = ST_PWR;
            ST_PWR: if (!pwrt_en || pwr_done)
                       state_d = (need_ost_q && is_xtal(osc_mode)) ? ST_OST : ST_RUN;
            ST_OST: if (ost_done) state_d = is_pll(osc_mode) ? ST_PLL : ST_RUN;
            ST_PLL: if (pll_done) state_d = ST_RUN;
            ST_RUN: if (wake && is_xtal(osc_mode)) state_d = ST_OST;
            default: state_d = ST_LOW;
         endcase
      end
   end

   always_ff @(posedge clk or posedge por_pulse) begin
      if (por_pulse) begin
         state_q    <= ST_PWR;
         need_ost_q <= 1'b1;
      end else begin
         state_q    <= state_d;
         need_ost_q <= need_ost_d;
      end
   end

   always_ff @(posedge clk or posedge arst_ext) begin
      if (arst_ext) chip_rst_q <= 1'b1;
      else          chip_rst_q <= (state_q != ST_RUN) || !ext_ok;
   end

   assign chip_rst = chip_rst_q;
endmodule

// File: rtl/rts_checker.sv
module rts_checker
   import rts_pkg::*;
(
   input logic       clk,
   input logic       por_pulse,
   input logic       ext_rst_n,
   input logic       bor_en,
   input logic       pwrt_en,
   input logic [2:0] osc_mode,
   input logic       chip_rst,
   input logic [2:0] state_q,
   input logic       pwr_done,
   input logic       bor_trip
);
   AST_POR_FORCES_RST: assert property (@(posedge clk)
      por_pulse |-> chip_rst); // R1

   AST_PIN_FORCES_RST: assert property (@(posedge clk)
      !ext_rst_n |-> chip_rst); // R1

   AST_PWR_WAITS_DONE: assert property (@(posedge clk) disable iff (por_pulse)
      (state_q == ST_PWR && pwrt_en && !pwr_done && !bor_trip) |=> (state_q == ST_PWR)); // R2

   AST_OST_XTAL_ONLY: assert property (@(posedge clk) disable iff (por_pulse)
      (state_q == ST_OST) |-> is_xtal(osc_mode)); // R4

   AST_PLL_MODE_ONLY: assert property (@(posedge clk) disable iff (por_pulse)
      (state_q == ST_PLL) |-> (osc_mode == MODE_HSPLL)); // R5

   AST_LOW_HOLDS_RST: assert property (@(posedge clk) disable iff (por_pulse)
      (state_q == ST_LOW) |=> chip_rst); // R8

   AST_BOR_OFF_NO_LOW: assert property (@(posedge clk) disable iff (por_pulse)
      (!bor_en && state_q != ST_LOW) |=> (state_q != ST_LOW)); // R10

   AST_RELEASE_FROM_RUN: assert property (@(posedge clk) disable iff (por_pulse)
      $fell(chip_rst) |-> ($past(state_q) == ST_RUN)); // R13
endmodule

bind rst_timeout_seq rts_checker i_rts_checker (
   .clk      (clk),
   .por_pulse(por_pulse),
   .ext_rst_n(ext_rst_n),
   .bor_en   (bor_en),
   .pwrt_en  (pwrt_en),
   .osc_mode (osc_mode),
   .chip_rst (chip_rst),
   .state_q  (state_q),
   .pwr_done (pwr_done),
   .bor_trip (bor_trip)
);

// File: tb/test_rst_timeout_seq.sv
`timescale 1ns/1ps
module test_rst_timeout_seq;
   localparam int PWRT_T = 20;
   localparam int OST_C  = 64;
   localparam int PLL_C  = 32;
   localparam int BMIN   = 4;

   logic       clk = 1'b0;
   logic       por_pulse = 1'b1;
   logic       rc_tick = 1'b0;
   logic       vdd_low = 1'b0;
   logic       ext_rst_n = 1'b1;
   logic       wake = 1'b0;
   logic [2:0] osc_mode = 3'd1;
   logic       pwrt_en = 1'b1;
   logic       bor_en = 1'b1;
   logic       chip_rst;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 0;

   rst_timeout_seq #(
      .SYNC_STAGES(2), .PWRT_TICKS(PWRT_T), .OST_CYCLES(OST_C),
      .PLL_CYCLES(PLL_C), .BOR_MIN_TICKS(BMIN)
   ) i_rst_timeout_seq (
      .clk(clk), .por_pulse(por_pulse), .rc_tick(rc_tick), .vdd_low(vdd_low),
      .ext_rst_n(ext_rst_n), .wake(wake), .osc_mode(osc_mode),
      .pwrt_en(pwrt_en), .bor_en(bor_en), .chip_rst(chip_rst)
   );

   always #2 clk = ~clk;

   // RC tick: one rising edge every 8 clock cycles
   initial begin
      forever begin
         repeat (4) @(posedge clk);
         #1 rc_tick = ~rc_tick;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   task automatic chk_rng(input string req, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wait_release(input int maxc, output int n);
      n = 0;
      while (chip_rst && n < maxc) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic power_on(input logic [2:0] mode, input logic pw, input logic be);
      @(negedge clk);
      por_pulse = 1'b1;
      osc_mode  = mode;
      pwrt_en   = pw;
      bor_en    = be;
      vdd_low   = 1'b0;
      repeat (3) @(negedge clk);
      por_pulse = 1'b0;
   endtask

   task automatic t_reset_state();
      #1;
      chk(chip_rst === 1'b1, "R1 reset during power-on", int'(chip_rst), 1);
   endtask

   task automatic t_por_xtal();
      int n;
      power_on(3'd1, 1'b1, 1'b1);
      wait_release(1000, n);
      chk_rng("R2 R4 crystal power-up release", n, 215, 242);
   endtask

   task automatic t_por_pll();
      int n;
      power_on(3'd6, 1'b1, 1'b1);
      wait_release(1000, n);
      chk_rng("R5 PLL power-up release", n, 248, 276);
   endtask

   task automatic t_por_xtal_nopwrt();
      int n;
      power_on(3'd2, 1'b0, 1'b1);
      wait_release(1000, n);
      chk_rng("R3 crystal without power-up delay", n, 62, 75);
   endtask

   task automatic t_por_ec();
      int n;
      power_on(3'd4, 1'b0, 1'b1);
      wait_release(1000, n);
      chk_rng("R6 external clock without delay", n, 1, 4);
      power_on(3'd3, 1'b1, 1'b1);
      wait_release(1000, n);
      chk_rng("R2 RC mode power-up delay only", n, 150, 178);
   endtask

   task automatic t_bor_short();
      int hi = 0;
      power_on(3'd4, 1'b0, 1'b1);
      repeat (10) @(negedge clk);
      vdd_low = 1'b1;
      repeat (16) @(negedge clk);
      vdd_low = 1'b0;
      repeat (20) begin
         @(negedge clk);
         if (chip_rst) hi++;
      end
      chk(hi == 0, "R7 short dip ignored", hi, 0);
   endtask

   task automatic t_bor_long();
      int n;
      power_on(3'd1, 1'b0, 1'b1);
      repeat (80) @(negedge clk);
      chk(chip_rst === 1'b0, "R3 crystal released before dip", int'(chip_rst), 0);
      pwrt_en = 1'b1;
      vdd_low = 1'b1;
      repeat (60) @(negedge clk);
      chk(chip_rst === 1'b1, "R7 long dip asserts reset", int'(chip_rst), 1);
      repeat (200) @(negedge clk);
      chk(chip_rst === 1'b1, "R8 held while supply low", int'(chip_rst), 1);
      vdd_low = 1'b0;
      wait_release(1000, n);
      chk_rng("R8 power-up delay only after brown-out", n, 150, 178);
   endtask

   task automatic t_bor_restart();
      int n;
      vdd_low = 1'b1;
      repeat (60) @(negedge clk);
      vdd_low = 1'b0;
      repeat (100) @(negedge clk);
      chk(chip_rst === 1'b1, "R9 still in power-up delay", int'(chip_rst), 1);
      vdd_low = 1'b1;
      repeat (60) @(negedge clk);
      vdd_low = 1'b0;
      wait_release(1000, n);
      chk_rng("R9 power-up delay restarted", n, 150, 178);
   endtask

   task automatic t_bor_off();
      int hi = 0;
      bor_en  = 1'b0;
      vdd_low = 1'b1;
      repeat (100) begin
         @(negedge clk);
         if (chip_rst) hi++;
      end
      vdd_low = 1'b0;
      bor_en  = 1'b1;
      chk(hi == 0, "R10 brown-out disabled", hi, 0);
   endtask

   task automatic t_ext_run();
      int n;
      @(negedge clk);
      #0.5 ext_rst_n = 1'b0;
      #0.5;
      chk(chip_rst === 1'b1, "R1 pin asserts without clock", int'(chip_rst), 1);
      repeat (10) @(negedge clk);
      ext_rst_n = 1'b1;
      wait_release(100, n);
      chk_rng("R11 pin release in run", n, 2, 3);
   endtask

   task automatic t_ext_over_por();
      int n;
      @(negedge clk);
      ext_rst_n = 1'b0;
      power_on(3'd6, 1'b1, 1'b1);
      repeat (320) @(negedge clk);
      chk(chip_rst === 1'b1, "R11 held by pin", int'(chip_rst), 1);
      ext_rst_n = 1'b1;
      wait_release(100, n);
      chk_rng("R11 immediate release after time-outs", n, 2, 3);
   endtask

   task automatic t_wake(input logic [2:0] mode, input int lo, input int hi);
      int n;
      @(negedge clk);
      osc_mode = mode;
      wake     = 1'b1;
      @(negedge clk);
      wake = 1'b0;
      @(negedge clk);
      chk(chip_rst === 1'b1, "R12 wake asserts reset", int'(chip_rst), 1);
      wait_release(1000, n);
      chk_rng("R12 wake start-up chain", n, lo, hi);
   endtask

   task automatic t_wake_ignored();
      int hi = 0;
      @(negedge clk);
      osc_mode = 3'd7;
      wake     = 1'b1;
      @(negedge clk);
      wake = 1'b0;
      repeat (10) begin
         @(negedge clk);
         if (chip_rst) hi++;
      end
      chk(hi == 0, "R12 wake ignored in external clock mode", hi, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_por_xtal();
      t_por_pll();
      t_por_xtal_nopwrt();
      t_por_ec();
      t_bor_short();
      t_bor_long();
      t_bor_restart();
      t_bor_off();
      t_ext_run();
      t_ext_over_por();
      t_wake(3'd0, 60, 72);
      t_wake(3'd6, 93, 106);
      t_wake_ignored();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule